// File: doc/BRIEF.md
# Effective Address and Stack Unit

This unit holds the eight 20-bit architectural registers of an accumulator-style word-addressed processor and turns the addressing fields of a memory-reference instruction into a memory address. Registers 0 to 6 are A, B, C, D, S (stack pointer), X and Y. Register 7 is Z, the program counter. When register 7 is named as an address base it means Z. When it is named as an operand source it means the immediate value instead.

Three operations are supported. Register-indirect addressing takes a 4-bit signed adjustment and a pre/post flag, so plain indirect, auto-increment and auto-decrement all use one encoding. Indexed addressing adds a full-word displacement, taken from the extension word, to a base register and steps Z past that extension word. Jump-to-subroutine reads the target from the effective address, pushes Z onto the stack below S, and then loads Z with the target. The ALU returns its results through a plain register write port. Memory timing, the ALU and instruction fetch sit outside the unit.

Top module: `ea_stack_unit`

## Requirements
- R1: After reset every register (A to Y, and Z seen on `pc`) reads zero, and `busy` and `mem_req` are low.
- R2: `alu_we` writes `alu_data` into register `alu_sel` (0=A,1=B,2=C,3=D,4=S,5=X,6=Y,7=Z) at the clock edge. `src_data` returns register `src_sel` for codes 0 to 6 and returns `imm` for code 7. `pc` always shows Z.
- R3: Indirect (`op_kind`=0) with `pre_adj`=0 addresses the unchanged base value. At the edge the base register becomes base plus the sign-extended `adj` (range -8..+7), and `wb_valid`/`wb_sel`/`wb_data` report that update.
- R4: Indirect with `pre_adj`=1 addresses base plus the sign-extended `adj`, and the base register takes that same sum.
- R5: A zero `adj` produces no write-back: `wb_valid` stays low and the base register keeps its value.
- R6: Indexed (`op_kind`=1) addresses base plus `disp`. It leaves the base register unchanged and advances Z by one. A base code of 7 uses Z's value from before the step.
- R7: With `byte_mode`=1, `mem_addr` is effective value bits [19:1] and `mem_lane` is bit 0. Lane 0 is the low 10 bits of the word (little-endian). With `byte_mode`=0, `mem_addr` is bits [18:0] and `mem_lane` is 0. Jump-to-subroutine always uses word addressing.
- R8: Jump-to-subroutine (`op_kind`=2) first reads the word at the indirect effective address, with adjustment and write-back as in R3 to R5, and keeps it as target T. In the next cycle `busy` is high and the unit writes Z to address S-1 (`mem_we`=1, `mem_wdata`=Z). At that edge S becomes S-1 and Z becomes T.
- R9: An operation presented while `busy` is high is ignored: no address is computed, there is no write-back and no register changes.
- R10: When an ALU write and an address write-back target the same register in one cycle, the write-back wins. ALU writes to other registers still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 indirect, 1 indexed, 2 jump-to-subroutine, 3 none |
| base_sel | input | 3 | Base register code (7 = Z) |
| adj | input | 4 | Signed adjustment for indirect forms |
| pre_adj | input | 1 | 1 applies adjustment before use |
| byte_mode | input | 1 | Byte addressing of the operand |
| disp | input | 20 | Extension-word displacement for indexed |
| mem_rdata | input | 20 | Memory read data (same cycle as address) |
| alu_we | input | 1 | ALU result write enable |
| alu_sel | input | 3 | ALU result register code |
| alu_data | input | 20 | ALU result value |
| src_sel | input | 3 | Operand source code (7 = immediate) |
| imm | input | 20 | Immediate operand value |
| busy | output | 1 | Stack push cycle in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 19 | Word address |
| mem_lane | output | 1 | Byte lane within the word |
| mem_wdata | output | 20 | Write data (Z during push) |
| wb_valid | output | 1 | Base register updated this cycle |
| wb_sel | output | 3 | Register code of the update |
| wb_data | output | 20 | New base value |
| src_data | output | 20 | Selected operand value |
| pc | output | 20 | Current Z |

## Verification
The hardest state to reach is a jump-to-subroutine whose base register is S itself with a nonzero adjustment. There the push must use the stack pointer that the first cycle has just modified, and the target read depends on the pre/post choice. The bench sweeps every base register, including S and Z, across several adjustments in both pre and post forms. In each push cycle it also presents a competing indirect operation, so it can confirm at the ports that the push is not disturbed and that the competing operation's base register stays as it was.

// File: rtl/ea_stack_pkg.sv
package ea_stack_pkg;
   typedef enum logic [1:0] {
      OPK_INDIRECT = 2'd0,
      OPK_INDEXED  = 2'd1,
      OPK_CALL     = 2'd2,
      OPK_NONE     = 2'd3
   } opk_e;

   localparam int REG_COUNT = 8;
   localparam int SEL_W     = 3;
   localparam int REG_SP    = 4;
   localparam int REG_PC    = 7;
endpackage

// File: rtl/ea_regfile.sv
module ea_regfile
   import ea_stack_pkg::*;
#(
   parameter int WORD_W = 20
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 alu_we,
   input  logic [SEL_W-1:0]                     alu_sel,
   input  logic [WORD_W-1:0]                    alu_data,
   input  logic                                 wb_we,
   input  logic [SEL_W-1:0]                     wb_sel,
   input  logic [WORD_W-1:0]                    wb_data,
   input  logic                                 pc_we,
   input  logic [WORD_W-1:0]                    pc_data,
   input  logic                                 sp_we,
   input  logic [WORD_W-1:0]                    sp_data,
   output logic [REG_COUNT-1:0][WORD_W-1:0]     q
);

   if (REG_COUNT != (1 << SEL_W)) begin : g_bad_count
      $error("register count must fill the select code");
   end

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      logic              hi_we;
      logic [WORD_W-1:0] hi_data;
      logic [WORD_W-1:0] r;

      if (g == REG_SP) begin : g_sp
         assign hi_we   = sp_we;
         assign hi_data = sp_data;
      end else if (g == REG_PC) begin : g_pc
         assign hi_we   = pc_we;
         assign hi_data = pc_data;
      end else begin : g_plain
         assign hi_we   = 1'b0;
         assign hi_data = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (hi_we)
            r <= hi_data;
         else if (wb_we && (wb_sel == SEL_W'(g)))
            r <= wb_data;
         else if (alu_we && (alu_sel == SEL_W'(g)))
            r <= alu_data;
      end

      assign q[g] = r;
   end

   // R1: first edge after reset release sees a cleared file
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == '0));

   // R10: an address write-back always lands, even against an ALU write
   p_wb_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && !(pc_we && wb_sel == SEL_W'(REG_PC)) && !(sp_we && wb_sel == SEL_W'(REG_SP)))
      |=> (q[$past(wb_sel)] == $past(wb_data)));

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
   import ea_stack_pkg::*;
#(
   parameter int WORD_W  = 20,
   parameter int ADR_W   = 19,
   parameter int ADJ_W   = 4,
   parameter bit BYTE_EN = 1'b1
) (
   input  logic [1:0]        kind,
   input  logic [WORD_W-1:0] base_val,
   input  logic [ADJ_W-1:0]  adj,
   input  logic              pre_adj,
   input  logic              byte_mode,
   input  logic [WORD_W-1:0] disp,
   output logic [WORD_W-1:0] eff,
   output logic [WORD_W-1:0] adjusted,
   output logic              wb_need,
   output logic [ADR_W-1:0]  addr,
   output logic              lane
);

   localparam int EXT_W = WORD_W - ADJ_W;

   if (ADJ_W >= WORD_W) begin : g_bad_adj
      $error("adjustment field must be narrower than a word");
   end
   if (ADR_W >= WORD_W) begin : g_bad_adr
      $error("address must be narrower than a word");
   end

   opk_e              k;
   logic [WORD_W-1:0] adj_ext;
   logic [WORD_W-1:0] idx_sum;
   logic              indirect_form;

   always_comb begin
      k             = opk_e'(kind);
      adj_ext       = {{EXT_W{adj[ADJ_W-1]}}, adj};
      adjusted      = base_val + adj_ext;
      idx_sum       = base_val + disp;
      indirect_form = (k == OPK_INDIRECT) || (k == OPK_CALL);
      if (k == OPK_INDEXED)
         eff = idx_sum;
      else if (pre_adj)
         eff = adjusted;
      else
         eff = base_val;
      wb_need = indirect_form && (adj != '0);
   end

   if (BYTE_EN) begin : g_byte
      logic use_byte;
      assign use_byte = byte_mode && (k != OPK_CALL);
      assign addr     = use_byte ? eff[ADR_W:1] : eff[ADR_W-1:0];
      assign lane     = use_byte & eff[0];
   end else begin : g_word
      logic unused_byte;
      assign unused_byte = byte_mode;
      assign addr        = eff[ADR_W-1:0];
      assign lane        = 1'b0;
   end

endmodule

// File: rtl/ea_push_seq.sv
module ea_push_seq #(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] target,
   output logic              busy,
   output logic [WORD_W-1:0] t_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         t_q  <= '0;
      end else begin
         busy <= start && !busy;
         if (start && !busy)
            t_q <= target;
      end
   end

   // R8: push occupies exactly one cycle after the target read
   p_push_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   p_push_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

// File: rtl/ea_stack_unit.sv
module ea_stack_unit
   import ea_stack_pkg::*;
#(
   parameter int WORD_W  = 20,
   parameter int ADR_W   = 19,
   parameter int ADJ_W   = 4,
   parameter bit BYTE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [2:0]        base_sel,
   input  logic [ADJ_W-1:0]  adj,
   input  logic              pre_adj,
   input  logic              byte_mode,
   input  logic [WORD_W-1:0] disp,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              alu_we,
   input  logic [2:0]        alu_sel,
   input  logic [WORD_W-1:0] alu_data,
   input  logic [2:0]        src_sel,
   input  logic [WORD_W-1:0] imm,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADR_W-1:0]  mem_addr,
   output logic              mem_lane,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              wb_valid,
   output logic [2:0]        wb_sel,
   output logic [WORD_W-1:0] wb_data,
   output logic [WORD_W-1:0] src_data,
   output logic [WORD_W-1:0] pc
);

   localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

   logic [REG_COUNT-1:0][WORD_W-1:0] rf_q;
   logic              accept;
   opk_e              k;
   logic [WORD_W-1:0] eff;
   logic [WORD_W-1:0] adjusted;
   logic              wb_need;
   logic [ADR_W-1:0]  calc_addr;
   logic              calc_lane;
   logic [WORD_W-1:0] t_q;
   logic              call_start;
   logic              pc_we;
   logic [WORD_W-1:0] pc_data;
   logic [WORD_W-1:0] sp_dec;

   assign k          = opk_e'(op_kind);
   assign accept     = op_valid && !busy;
   assign call_start = accept && (k == OPK_CALL);

   ea_addr_gen #(
      .WORD_W (WORD_W),
      .ADR_W  (ADR_W),
      .ADJ_W  (ADJ_W),
      .BYTE_EN(BYTE_EN)
   ) i_addr (
      .kind     (op_kind),
      .base_val (rf_q[base_sel]),
      .adj      (adj),
      .pre_adj  (pre_adj),
      .byte_mode(byte_mode),
      .disp     (disp),
      .eff      (eff),
      .adjusted (adjusted),
      .wb_need  (wb_need),
      .addr     (calc_addr),
      .lane     (calc_lane)
   );

   ea_push_seq #(.WORD_W(WORD_W)) i_push (
      .clk   (clk),
      .rst_n (rst_n),
      .start (call_start),
      .target(mem_rdata),
      .busy  (busy),
      .t_q   (t_q)
   );

   always_comb begin
      sp_dec    = rf_q[REG_SP] - ONE;
      wb_valid  = accept && wb_need;
      wb_sel    = base_sel;
      wb_data   = adjusted;
      pc_we     = busy || (accept && (k == OPK_INDEXED));
      pc_data   = busy ? t_q : (rf_q[REG_PC] + ONE);
      mem_req   = busy || (accept && (k != OPK_NONE));
      mem_we    = busy;
      mem_addr  = busy ? sp_dec[ADR_W-1:0] : calc_addr;
      mem_lane  = busy ? 1'b0 : calc_lane;
      mem_wdata = rf_q[REG_PC];
      src_data  = (src_sel == SEL_W'(REG_PC)) ? imm : rf_q[src_sel];
      pc        = rf_q[REG_PC];
   end

   ea_regfile #(.WORD_W(WORD_W)) i_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .alu_we  (alu_we),
      .alu_sel (alu_sel),
      .alu_data(alu_data),
      .wb_we   (wb_valid),
      .wb_sel  (wb_sel),
      .wb_data (wb_data),
      .pc_we   (pc_we),
      .pc_data (pc_data),
      .sp_we   (busy),
      .sp_data (sp_dec),
      .q       (rf_q)
   );

   // R8: push cycle is a write, stack drops by one, Z takes the target
   p_push_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mem_req && mem_we));
   p_stack_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (rf_q[REG_SP] == $past(rf_q[REG_SP]) - ONE));
   p_pc_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (pc == $past(t_q)));
   // R6: indexed steps Z past its extension word
   p_idx_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && k == OPK_INDEXED) |=> (pc == $past(pc) + ONE));
   // R9: nothing is written back during the push cycle
   p_busy_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wb_valid);

endmodule

// File: tb/test_ea_stack_unit.sv
module test_ea_stack_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'd3;
   logic [2:0]  base_sel = '0;
   logic [3:0]  adj = '0;
   logic        pre_adj = 1'b0;
   logic        byte_mode = 1'b0;
   logic [19:0] disp = '0;
   logic [19:0] mem_rdata;
   logic        alu_we = 1'b0;
   logic [2:0]  alu_sel = '0;
   logic [19:0] alu_data = '0;
   logic [2:0]  src_sel = '0;
   logic [19:0] imm = '0;
   logic        busy, mem_req, mem_we, mem_lane, wb_valid;
   logic [18:0] mem_addr;
   logic [19:0] mem_wdata, wb_data, src_data, pc;
   logic [2:0]  wb_sel;

   int n_chk = 0;
   int n_fail = 0;
   logic [19:0] m [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory image: word at address a holds a ^ 5A5A5
   assign mem_rdata = {1'b0, mem_addr} ^ 20'h5A5A5;

   ea_stack_unit i_ea_stack_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .base_sel(base_sel), .adj(adj), .pre_adj(pre_adj), .byte_mode(byte_mode),
      .disp(disp), .mem_rdata(mem_rdata), .alu_we(alu_we), .alu_sel(alu_sel),
      .alu_data(alu_data), .src_sel(src_sel), .imm(imm), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_lane(mem_lane),
      .mem_wdata(mem_wdata), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data),
      .src_data(src_data), .pc(pc)
   );

   task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic get_reg(input int idx, output logic [19:0] v);
      if (idx == 7) v = pc;
      else begin
         src_sel = 3'(idx);
         #1;
         v = src_data;
      end
   endtask

   task automatic check_reg(input int idx, input string req);
      logic [19:0] v;
      @(negedge clk);
      get_reg(idx, v);
      chk(v === m[idx], req, v, m[idx]);
   endtask

   task automatic write_reg(input int idx, input logic [19:0] val);
      @(negedge clk);
      alu_we = 1'b1; alu_sel = 3'(idx); alu_data = val;
      @(posedge clk); #1;
      alu_we = 1'b0;
      m[idx] = val;
   endtask

   task automatic clear_op();
      op_valid = 1'b0; op_kind = 2'd3; alu_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [19:0] v, e, ex, t;
      for (int i = 0; i < 8; i++) m[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(busy === 1'b0, "R1 busy after reset", {19'd0, busy}, 20'd0);
      chk(mem_req === 1'b0, "R1 mem_req after reset", {19'd0, mem_req}, 20'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) check_reg(i, "R1 register cleared");

      // R2 write every register, read back, immediate on code 7
      for (int i = 0; i < 8; i++) write_reg(i, 20'(32'h1111 * (i + 1) + 32'h30000));
      for (int i = 0; i < 8; i++) check_reg(i, "R2 register readback");
      @(negedge clk);
      src_sel = 3'd7; imm = 20'hC0FFE; #1;
      chk(src_data === 20'hC0FFE, "R2 code 7 source is immediate", src_data, 20'hC0FFE);

      // R3 R4 R5 R7 indirect sweep
      for (int b = 0; b < 8; b++)
         for (int a = -8; a < 8; a++)
            for (int p = 0; p < 2; p++)
               for (int by = 0; by < 2; by++) begin
                  v = 20'(b * 32'h1357 + (a + 8) * 32'h91 + p * 32'h40000 + by * 3 + 32'h8000);
                  write_reg(b, v);
                  ex = v + 20'(a);
                  e  = (p != 0) ? ex : v;
                  @(negedge clk);
                  op_valid = 1'b1; op_kind = 2'd0; base_sel = 3'(b); adj = 4'(a);
                  pre_adj = 1'(p); byte_mode = 1'(by);
                  #1;
                  if (by != 0) begin
                     chk(mem_addr === e[19:1], "R7 byte word address", {1'b0, mem_addr}, {1'b0, e[19:1]});
                     chk(mem_lane === e[0], "R7 byte lane", {19'd0, mem_lane}, {19'd0, e[0]});
                  end else begin
                     chk(mem_addr === e[18:0], (p != 0) ? "R4 pre-adjust address" : "R3 post-adjust address",
                         {1'b0, mem_addr}, {1'b0, e[18:0]});
                     chk(mem_lane === 1'b0, "R7 word lane zero", {19'd0, mem_lane}, 20'd0);
                  end
                  chk(wb_valid === (a != 0), "R5 write-back only for nonzero adjust",
                      {19'd0, wb_valid}, {19'd0, 1'(a != 0)});
                  if (a != 0) begin
                     chk(wb_data === ex && wb_sel === 3'(b), "R3 write-back value", wb_data, ex);
                     m[b] = ex;
                  end
                  @(posedge clk); #1;
                  clear_op();
                  check_reg(b, (a == 0) ? "R5 base unchanged" : ((p != 0) ? "R4 base updated" : "R3 base updated"));
               end

      // R6 R7 indexed sweep
      for (int b = 0; b < 8; b++)
         for (int kd = 0; kd < 5; kd++)
            for (int by = 0; by < 2; by++) begin
               logic [19:0] d;
               case (kd)
                  0: d = 20'h00000;
                  1: d = 20'h00001;
                  2: d = 20'hFFFFF;
                  3: d = 20'h80000;
                  default: d = 20'h12345;
               endcase
               write_reg(b, 20'(b * 32'h2468 + kd * 32'h777 + 32'h100));
               e = m[b] + d;
               @(negedge clk);
               op_valid = 1'b1; op_kind = 2'd1; base_sel = 3'(b); disp = d;
               byte_mode = 1'(by); adj = 4'd5; pre_adj = 1'b1;
               #1;
               if (by != 0)
                  chk(mem_addr === e[19:1] && mem_lane === e[0], "R7 indexed byte address",
                      {1'b0, mem_addr}, {1'b0, e[19:1]});
               else
                  chk(mem_addr === e[18:0] && mem_lane === 1'b0, "R6 indexed address",
                      {1'b0, mem_addr}, {1'b0, e[18:0]});
               chk(wb_valid === 1'b0, "R6 no base write-back", {19'd0, wb_valid}, 20'd0);
               @(posedge clk); #1;
               clear_op();
               m[7] = m[7] + 20'd1;
               check_reg(7, "R6 Z steps past extension word");
               if (b != 7) check_reg(b, "R6 base unchanged");
            end

      // R8 R9 jump-to-subroutine sweep, including S and Z as base
      for (int b = 0; b < 8; b++)
         for (int ka = 0; ka < 3; ka++)
            for (int p = 0; p < 2; p++) begin
               int a;
               a = (ka == 0) ? -2 : ((ka == 1) ? 0 : 3);
               write_reg(4, 20'(32'h00400 + b * 16));
               write_reg(7, 20'(32'h12340 + b));
               write_reg(0, 20'h0AAAA);
               if (b != 4 && b != 7 && b != 0) write_reg(b, 20'(32'h05000 + b * 32'h101));
               v  = m[b];
               ex = v + 20'(a);
               e  = (p != 0) ? ex : v;
               t  = {1'b0, e[18:0]} ^ 20'h5A5A5;
               @(negedge clk);
               op_valid = 1'b1; op_kind = 2'd2; base_sel = 3'(b); adj = 4'(a);
               pre_adj = 1'(p); byte_mode = 1'b1;
               #1;
               chk(mem_addr === e[18:0] && mem_we === 1'b0 && mem_lane === 1'b0,
                   "R8 target read at word address", {1'b0, mem_addr}, {1'b0, e[18:0]});
               if (a != 0) m[b] = ex;
               @(posedge clk); #1;
               clear_op();
               @(negedge clk);
               // competing op during push must be ignored
               op_valid = 1'b1; op_kind = 2'd0; base_sel = 3'd0; adj = 4'd3; pre_adj = 1'b0;
               #1;
               ex = m[4] - 20'd1;
               chk(busy === 1'b1 && mem_we === 1'b1, "R8 push cycle write", {18'd0, busy, mem_we}, 20'd3);
               chk(mem_addr === ex[18:0], "R8 push address S-1", {1'b0, mem_addr}, {1'b0, ex[18:0]});
               chk(mem_wdata === m[7], "R8 pushed Z", mem_wdata, m[7]);
               chk(wb_valid === 1'b0, "R9 no write-back while busy", {19'd0, wb_valid}, 20'd0);
               @(posedge clk); #1;
               clear_op();
               m[4] = ex;
               m[7] = t;
               chk(busy === 1'b0, "R8 busy for one cycle", {19'd0, busy}, 20'd0);
               check_reg(7, "R8 Z loaded with target");
               check_reg(4, "R8 S decremented");
               check_reg(0, "R9 ignored op left A alone");
            end

      // R10 priority of write-back over ALU port
      write_reg(1, 20'h00100);
      @(negedge clk);
      op_valid = 1'b1; op_kind = 2'd0; base_sel = 3'd1; adj = 4'd1; pre_adj = 1'b0; byte_mode = 1'b0;
      alu_we = 1'b1; alu_sel = 3'd1; alu_data = 20'hABCDE;
      @(posedge clk); #1;
      clear_op();
      m[1] = 20'h00101;
      check_reg(1, "R10 write-back beats ALU write");
      @(negedge clk);
      op_valid = 1'b1; op_kind = 2'd0; base_sel = 3'd1; adj = 4'hF; pre_adj = 1'b1;
      alu_we = 1'b1; alu_sel = 3'd2; alu_data = 20'h13579;
      @(posedge clk); #1;
      clear_op();
      m[1] = 20'h00100;
      m[2] = 20'h13579;
      check_reg(1, "R10 base updated alongside ALU write");
      check_reg(2, "R10 ALU write to other register lands");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule